// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a small set of registers in which every register exists once per hardware unit. All copies of a register answer at the same bus offset. A selector register picks a group and an instance, and that pair steers each bus access to one copy. When the selector's broadcast bit is set, a write goes to every copy at once. Reads are never broadcast. They always return the one copy that the selector names.

An availability mask marks each unit as present or absent. A unit is absent when it is fused off or power-gated. An access steered to an absent unit is terminated: a read returns zero and a write is dropped. Units are numbered `group * N_INST + instance`, and bit `u` of the mask belongs to unit `u`. The selector has its own offset, is not replicated and can be read back, so software can save its value and restore it around a steered access. Any other offset outside the bank returns zero and raises an error pulse.

Top module: `steer_regbank`

## Requirements
- R1: After reset every copy holds zero and the selector reads back as group 0, instance 0, broadcast set (word value 0x0001_0000).
- R2: The selector sits at address 0 and is written and read there. The instance field is in bits [IW-1:0], the group field starts at bit 8 and the broadcast flag is bit 16. All other bits read as zero.
- R3: Replicated register k is reached at address 4 + k, for k from 0 to N_REGS-1.
- R4: A write to the bank with the broadcast flag clear changes only the copy of unit `group*N_INST+instance`.
- R5: A write to the bank with the broadcast flag set stores the same value into that register's copy in every available unit.
- R6: A bank read returns the copy of the steered unit, whatever the broadcast flag holds.
- R7: A bank read steered to a unit whose availability bit is 0 returns zero.
- R8: A unicast write steered to an unavailable unit is dropped, and the copy keeps its old value once the unit becomes available again.
- R9: A broadcast write leaves the copies of unavailable units unchanged.
- R10: An access to any address other than 0 or 4..4+N_REGS-1 reads zero and changes no state. Such an access drives err_o high in the next cycle only.
- R11: Read data is registered. rdata_o carries the result in the cycle after rd_en_i and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| avail_i | input | N_GROUPS*N_INST | Availability bit per unit |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle flag for an access outside the map |

## Verification
A write is committed at the clock edge where it is presented, so a read issued in the following cycle already sees the new value. Read data and the error flag both appear one edge after the access. The bench therefore presents each access for one cycle between falling edges and samples rdata_o and err_o at the next falling edge. It checks that err_o has cleared and rdata_o has returned to zero one cycle later again. Every copy of every register is swept under unicast steering, broadcast steering and several availability masks, and the expected values come from a shadow model kept in the bench.

// File: rtl/steer_regbank_pkg.sv
package steer_regbank_pkg;
    // Fixed selector layout, shared by RTL and software view
    localparam int SEL_GRP_LSB = 8;
    localparam int SEL_MC_BIT  = 16;

    typedef enum logic [1:0] {
        ACC_SEL  = 2'd0,
        ACC_BANK = 2'd1,
        ACC_MISS = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/steer_decode.sv
module steer_decode
    import steer_regbank_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int N_REGS    = 4,
    parameter int SEL_ADDR  = 0,
    parameter int BANK_BASE = 4,
    parameter int RW        = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [RW-1:0]     reg_idx_o
);
    logic in_bank;

    always_comb begin
        in_bank   = ({1'b0, addr_i} >= (ADDR_W+1)'(BANK_BASE)) &&
                    ({1'b0, addr_i} <  (ADDR_W+1)'(BANK_BASE + N_REGS));
        reg_idx_o = RW'(addr_i - ADDR_W'(BANK_BASE));
        if (addr_i == ADDR_W'(SEL_ADDR))
            kind_o = ACC_SEL;
        else if (in_bank)
            kind_o = ACC_BANK;
        else
            kind_o = ACC_MISS;
    end
endmodule

// File: rtl/steer_unit.sv
module steer_unit #(
    parameter int N_REGS = 4,
    parameter int DATA_W = 32,
    parameter int RW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [RW-1:0]     idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rval_o
);
    logic [N_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i)
            regs_d[idx_i] = wdata_i;
        rval_o = regs_q[idx_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    AST_UNIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(regs_q)); // R8
endmodule

// File: rtl/steer_regbank.sv
module steer_regbank
    import steer_regbank_pkg::*;
#(
    parameter int N_GROUPS  = 2,
    parameter int N_INST    = 4,
    parameter int N_REGS    = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int SEL_ADDR  = 0,
    parameter int BANK_BASE = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         wr_en_i,
    input  logic                         rd_en_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [N_GROUPS*N_INST-1:0]   avail_i,
    output logic [DATA_W-1:0]            rdata_o,
    output logic                         err_o
);
    localparam int N_UNITS = N_GROUPS * N_INST;
    localparam int GW = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
    localparam int IW = (N_INST   > 1) ? $clog2(N_INST)   : 1;
    localparam int UW = (N_UNITS  > 1) ? $clog2(N_UNITS)  : 1;
    localparam int RW = (N_REGS   > 1) ? $clog2(N_REGS)   : 1;

    typedef struct packed {
        logic [GW-1:0]     grp;
        logic [IW-1:0]     inst;
        logic              mc;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } state_t;

    state_t s_d, s_q;

    acc_kind_e                     kind;
    logic [RW-1:0]                 reg_idx;
    logic [N_UNITS-1:0]            unit_we;
    logic [N_UNITS-1:0][DATA_W-1:0] unit_val;
    logic [UW-1:0]                 steer_u;
    logic                          steer_in;
    logic                          steer_live;
    logic                          bank_wr;
    logic [DATA_W-1:0]             sel_word;

    steer_decode #(
        .ADDR_W(ADDR_W), .N_REGS(N_REGS), .SEL_ADDR(SEL_ADDR),
        .BANK_BASE(BANK_BASE), .RW(RW)
    ) u_decode (
        .addr_i   (addr_i),
        .kind_o   (kind),
        .reg_idx_o(reg_idx)
    );

    always_comb begin
        steer_u    = UW'(int'(s_q.grp) * N_INST + int'(s_q.inst));
        steer_in   = (int'(s_q.grp) * N_INST + int'(s_q.inst)) < N_UNITS;
        steer_live = steer_in && avail_i[steer_u];
        bank_wr    = wr_en_i && (kind == ACC_BANK);
        sel_word   = '0;
        sel_word[IW-1:0]             = s_q.inst;
        sel_word[SEL_GRP_LSB +: GW]  = s_q.grp;
        sel_word[SEL_MC_BIT]         = s_q.mc;
    end

    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            assign unit_we[u] = bank_wr && avail_i[u] &&
                                (s_q.mc || (steer_in && steer_u == UW'(u)));
            steer_unit #(
                .N_REGS(N_REGS), .DATA_W(DATA_W), .RW(RW)
            ) u_copy (
                .clk    (clk),
                .rst_n  (rst_n),
                .we_i   (unit_we[u]),
                .idx_i  (reg_idx),
                .wdata_i(wdata_i),
                .rval_o (unit_val[u])
            );
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        s_d.err   = (rd_en_i || wr_en_i) && (kind == ACC_MISS);
        if (wr_en_i && kind == ACC_SEL) begin
            s_d.inst = wdata_i[IW-1:0];
            s_d.grp  = wdata_i[SEL_GRP_LSB +: GW];
            s_d.mc   = wdata_i[SEL_MC_BIT];
        end
        if (rd_en_i) begin
            if (kind == ACC_SEL)
                s_d.rdata = sel_word;
            else if (kind == ACC_BANK && steer_live)
                s_d.rdata = unit_val[steer_u];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mc    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o = s_q.rdata;
    assign err_o   = s_q.err;

    AST_MISS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en_i || wr_en_i) && kind == ACC_MISS) |=> err_o); // R10
    AST_ERR_ONLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_en_i || wr_en_i) && kind == ACC_MISS) |=> !err_o); // R10
    AST_TERM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && kind == ACC_BANK && !steer_live) |=> (rdata_o == '0)); // R7
    AST_UNICAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.mc |-> $onehot0(unit_we)); // R4
    AST_NO_DEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_we & ~avail_i) == '0); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rdata_o == '0)); // R11
endmodule

// File: tb/steer_regbank_tb.sv
module steer_regbank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 2, NI = 4, NR = 4, NU = NG * NI;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [NU-1:0] avail = '1;
    logic [31:0] rdata;
    logic        err;

    int checks = 0, errors = 0;
    logic [31:0] model [NU][NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    steer_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .wdata_i(wdata), .avail_i(avail),
        .rdata_o(rdata), .err_o(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rdata; e = err; rd_en = 1'b0;
    endtask

    function automatic logic [31:0] sel_word(input int g, input int i, input bit m);
        return (32'(m) << 16) | (32'(g) << 8) | 32'(i);
    endfunction

    task automatic steer(input int g, input int i, input bit m);
        do_write(4'd0, sel_word(g, i, m));
    endtask

    task automatic read_all(input string req);
        logic [31:0] d; logic e;
        for (int u = 0; u < NU; u++) begin
            steer(u / NI, u % NI, 1'b0);
            for (int r = 0; r < NR; r++) begin
                do_read(4'(4 + r), d, e);
                check(req, d, avail[u] ? model[u][r] : 32'h0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d; logic e;
        for (int u = 0; u < NU; u++)
            for (int r = 0; r < NR; r++) model[u][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset outputs and selector
        check("R1 rdata after reset", rdata, 32'h0);
        check("R1 err after reset", {31'h0, err}, 32'h0);
        do_read(4'd0, d, e);
        check("R1 selector reset", d, 32'h0001_0000);
        read_all("R1 copies zero");

        // R3/R4: unicast writes to every copy, then full readback
        for (int u = 0; u < NU; u++) begin
            steer(u / NI, u % NI, 1'b0);
            for (int r = 0; r < NR; r++) begin
                model[u][r] = 32'hA500_0000 | (32'(u) << 8) | 32'(r * 17 + 1);
                do_write(4'(4 + r), model[u][r]);
            end
        end
        read_all("R4 unicast sweep");

        // R11: read result then idle cycle returns zero
        steer(1, 1, 1'b0);
        do_read(4'd5, d, e);
        check("R3 offset 5 is reg1", d, model[5][1]);
        @(negedge clk);
        check("R11 idle rdata", rdata, 32'h0);

        // R5/R9: broadcast with a partial mask
        avail = 8'b1011_0101;
        steer(1, 2, 1'b1);
        do_write(4'd6, 32'hC0FF_EE00);
        for (int u = 0; u < NU; u++)
            if (avail[u]) model[u][2] = 32'hC0FF_EE00;
        do_read(4'd6, d, e);
        check("R7 read with broadcast to dead unit", d, 32'h0);
        steer(0, 0, 1'b1);
        do_read(4'd6, d, e);
        check("R6 read with broadcast set", d, 32'hC0FF_EE00);
        avail = '1;
        read_all("R5 R9 broadcast sweep");

        // R8: unicast write to absent unit dropped
        avail = 8'b1111_0111;
        steer(0, 3, 1'b0);
        do_write(4'd5, 32'hDEAD_BEEF);
        do_read(4'd5, d, e);
        check("R7 read dead unit", d, 32'h0);
        avail = '1;
        do_read(4'd5, d, e);
        check("R8 dropped write", d, model[3][1]);

        // R7: each unit masked in turn
        for (int u = 0; u < NU; u++) begin
            avail = ~(NU'(1) << u);
            steer(u / NI, u % NI, 1'b0);
            do_read(4'd4, d, e);
            check("R7 masked unit reads zero", d, 32'h0);
        end
        avail = '1;

        // R2: selector field layout with junk bits
        do_write(4'd0, 32'hFFFF_FFFF);
        do_read(4'd0, d, e);
        check("R2 selector readback", d, 32'h0001_0103);
        do_write(4'd0, 32'h0000_0102);
        do_read(4'd0, d, e);
        check("R2 selector unicast", d, 32'h0000_0102);
        do_read(4'd7, d, e);
        check("R6 steered to unit 6", d, model[6][3]);

        // R10: out-of-range accesses
        for (int a = 1; a < 16; a++) begin
            if (a >= 4 && a < 8) continue;
            do_read(4'(a), d, e);
            check("R10 miss data", d, 32'h0);
            check("R10 miss err", {31'h0, e}, 32'h1);
            @(negedge clk);
            check("R10 err one cycle", {31'h0, err}, 32'h0);
        end
        do_write(4'd9, 32'h1234_5678);
        check("R10 write miss err", {31'h0, err}, 32'h1);
        do_read(4'd0, d, e);
        check("R10 selector untouched", d, 32'h0000_0102);
        read_all("R10 bank untouched");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule